// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is the register-side face of a chip toward a host processor. The host has an 8-bit address bus and an 8-bit data bus. A strap input chooses the style of bus control. In the first style, read and write each have their own strobe. In the second, a single data strobe is qualified by a read/write line. Both styles reach one shared register file.

The register file holds three kinds of registers:
- A power-down control register with one bit for each of the two receive ports.
- An alarm status register and an interrupt mask register. Together they drive an open-drain interrupt, modelled here as a pull-low enable.
- Two windows of per-port scratch registers.

While a port is powered down, its window is frozen. Writes to it are dropped. Reads from it return the last value that was read from that port's window while the port was up. The stored contents stay intact and are readable again after power-up.

All host pins are taken as synchronous to `clk`. An access starts on the first clock in which the control pins form a valid read or write. One access is made per strobe assertion. Read data is registered and stays on `host_rdata` until the next read.

Top module: `hostreg_port`

## Requirements
- R1: After reset, `host_rdata`, the power-down bits, the mask, the alarm status, every window register and both per-port held values read 0x00, and `irq_pull_en` is 0.
- R2: With `bus_mode`=0 and `host_cs_n`=0, the control pins are decoded as follows:
  - `host_strb_n`=0 with `host_ctl`=1 is a read.
  - `host_ctl`=0 with `host_strb_n`=1 is a write.
  - Both low together is no access.
  - A strobe held for several cycles makes one access.
- R3: With `bus_mode`=1 and `host_cs_n`=0, the control pins are decoded as follows:
  - `host_strb_n`=0 starts an access, which is a read when `host_ctl`=1 and a write when `host_ctl`=0.
  - `host_strb_n`=1 is no access, whatever `host_ctl` is.
- R4: Read data appears on `host_rdata` one clock after the access starts and holds until the next read starts.
- R5: Addresses 0x20–0x45 (port A) and 0x60–0x85 (port B) are read/write byte registers. Reads of any other address apart from 0x01–0x03 return 0x00, and writes to those addresses change nothing.
- R6: Register 0x01 holds the power-down bits (bit 0 is port A, bit 1 is port B) and reads back. A write into a powered-down port's window is dropped, and the other port is unaffected.
- R7: A read of a powered-down port's window returns that port's held value. The held value is 0x00 after reset and is updated only by reads of that window while the port is up.
- R8: Window contents are kept through power-down and read back unchanged after power-up.
- R9: Register 0x03 is the alarm status. A pulse on `alarm_in[i]` sets bit i, and the bit stays set. Writing 1 to a bit clears it. An alarm pulse in the same cycle as a clear of that bit leaves the bit set.
- R10: Register 0x02 is the interrupt mask. A mask bit of 1 stops that alarm from driving the interrupt, but does not change its status bit.
- R11: `irq_pull_en` is 1 exactly when some status bit is set whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | Bus style strap: 0 = separate read/write strobes, 1 = data strobe with read/write line |
| host_cs_n | input | 1 | Chip select, active low |
| host_strb_n | input | 1 | Mode 0: read strobe (low). Mode 1: data strobe (low) |
| host_ctl | input | 1 | Mode 0: write strobe (low). Mode 1: 1 = read, 0 = write |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Write data from host |
| host_rdata | output | 8 | Registered read data to host |
| alarm_in | input | N_ALARM | Alarm pulses, one per interrupt source |
| irq_pull_en | output | 1 | Open-drain interrupt: 1 pulls the line low |

## Verification
The register file is exercised under both bus styles. The same addresses are written and read back in each style. Pin patterns that are legal in one style and idle or invalid in the other are also driven, which separates correct mode decoding from a decoder that ignores the strap.

Power-down is tested in several ways:
- The bench reads a window after prior reads of the other port and after no read at all. This separates a per-port held value from a shared one and from the addressed register.
- Dropped writes are checked by powering the port back up and reading the register.

Alarm tests cover:
- masked and unmasked sources;
- a clear of a different bit from the pending one;
- a clear in the same cycle as a new alarm.

Together these tell apart status priority, mask independence and interrupt gating.

// File: rtl/hostreg_pkg.sv
// Package: shared constants and types for the host register port.
// Assumes: 8-bit address and data buses.
package hostreg_pkg;

    typedef enum logic {
        BUS_SPLIT  = 1'b0,   // separate read and write strobes
        BUS_STROBE = 1'b1    // one data strobe plus read/write line
    } bus_mode_e;

    localparam logic [7:0] ADDR_PWRDN = 8'h01;
    localparam logic [7:0] ADDR_IMASK = 8'h02;
    localparam logic [7:0] ADDR_ISTAT = 8'h03;

endpackage

// File: rtl/hostreg_busdec.sv
// Module: hostreg_busdec
// Turns the host control pins into single-cycle read and write pulses,
// according to the bus-style strap.
// Assumes: pins are synchronous to clk. One pulse is made per strobe
// assertion, in its first cycle.
module hostreg_busdec
    import hostreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic cs_n,
    input  logic strb_n,
    input  logic ctl,
    output logic rd_pulse,
    output logic wr_pulse
);

    logic rd_act, wr_act;
    logic rd_q, wr_q;

    // Decode the pin levels into active read and write requests.
    always_comb begin
        if (mode == BUS_STROBE) begin
            rd_act = !cs_n && !strb_n && ctl;
            wr_act = !cs_n && !strb_n && !ctl;
        end else begin
            rd_act = !cs_n && !strb_n && ctl;
            wr_act = !cs_n && strb_n && !ctl;
        end
    end

    // Remember the previous request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_act;
            wr_q <= wr_act;
        end
    end

    assign rd_pulse = rd_act && !rd_q;
    assign wr_pulse = wr_act && !wr_q;

    // R2: a held strobe produces one access only.
    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);
    assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/hostreg_bank.sv
// Module: hostreg_bank
// One receive port's register window: byte storage, power-down gating
// and the last-read holding register.
// Assumes: window lies wholly within the 8-bit address space.
module hostreg_bank #(
    parameter int BASE = 8'h20,
    parameter int LEN  = 38
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_pulse,
    input  logic       wr_pulse,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       pd,
    output logic       hit,
    output logic [7:0] rdval
);

    localparam int IW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [LEN-1:0][7:0] mem;
    logic [7:0]          hold;
    logic [7:0]          off;
    logic [IW-1:0]       idx;
    logic [7:0]          cur;

    // Locate the address inside the window.
    always_comb begin
        off = addr - 8'(BASE);
        hit = (addr >= 8'(BASE)) && (off < 8'(LEN));
        idx = off[IW-1:0];
        cur = hit ? mem[idx] : 8'h00;
    end

    // Store host writes unless the port is powered down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_pulse && hit && !pd) begin
            mem[idx] <= wdata;
        end
    end

    // Capture the last value read while the port is up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= 8'h00;
        end else if (rd_pulse && hit && !pd) begin
            hold <= cur;
        end
    end

    assign rdval = pd ? hold : cur;

    // R6: a write into a powered-down window leaves storage untouched.
    assert_pd_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && hit && wr_pulse) |=> $stable(mem));
    // R7: a read while powered down does not move the held value.
    assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && hit && rd_pulse) |=> $stable(hold));

endmodule

// File: rtl/hostreg_irq.sv
// Module: hostreg_irq
// Sticky alarm status (write-1-to-clear), per-source mask, and the
// open-drain interrupt enable.
// Assumes: N <= 8 so both registers fit one data byte.
module hostreg_irq
    import hostreg_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_pulse,
    input  logic [7:0]   addr,
    input  logic [7:0]   wdata,
    input  logic [N-1:0] alarm_in,
    output logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq_pull_en
);

    logic         mask_wr;
    logic [N-1:0] clr;

    // Decode host writes to the mask and status registers.
    always_comb begin
        mask_wr = wr_pulse && (addr == ADDR_IMASK);
        clr     = (wr_pulse && (addr == ADDR_ISTAT)) ? wdata[N-1:0] : '0;
    end

    // Hold the mask value written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= wdata[N-1:0];
    end

    // Sticky status: alarms set bits, and win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | alarm_in;
    end

    assign irq_pull_en = |(status & ~mask);

    // R9: every alarm pulse leaves its status bit set on the next cycle.
    assert_alarm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|alarm_in) |=> ((status & $past(alarm_in)) == $past(alarm_in)));
    // R10: changing the mask never drops a pending status bit.
    assert_mask_keeps_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/hostreg_port.sv
// Module: hostreg_port (top)
// Host register interface serving both bus styles. It holds the
// power-down control, two gated receive-port windows, and the
// maskable alarm interrupt. Read data is registered.
// Assumes: host pins are synchronous to clk. Unmapped addresses read 0.
module hostreg_port
    import hostreg_pkg::*;
#(
    parameter int N_ALARM = 8,
    parameter int WIN_LEN = 38,
    parameter int A_BASE  = 8'h20,
    parameter int B_BASE  = 8'h60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_mode,
    input  logic               host_cs_n,
    input  logic               host_strb_n,
    input  logic               host_ctl,
    input  logic [7:0]         host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic [N_ALARM-1:0] alarm_in,
    output logic               irq_pull_en
);

    localparam int NPORT = 2;

    logic               rd_pulse, wr_pulse;
    logic [NPORT-1:0]   pd;
    logic [NPORT-1:0]   bank_hit;
    logic [7:0]         bank_rd [NPORT];
    logic [N_ALARM-1:0] mask, status;
    logic [7:0]         rd_mux;

    initial begin
        if (N_ALARM < 1 || N_ALARM > 8) $error("N_ALARM must be 1..8");
    end

    hostreg_busdec u_busdec (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (bus_mode),
        .cs_n     (host_cs_n),
        .strb_n   (host_strb_n),
        .ctl      (host_ctl),
        .rd_pulse (rd_pulse),
        .wr_pulse (wr_pulse)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_bank
        localparam int BASE_G = (g == 0) ? A_BASE : B_BASE;
        hostreg_bank #(.BASE(BASE_G), .LEN(WIN_LEN)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_pulse (rd_pulse),
            .wr_pulse (wr_pulse),
            .addr     (host_addr),
            .wdata    (host_wdata),
            .pd       (pd[g]),
            .hit      (bank_hit[g]),
            .rdval    (bank_rd[g])
        );
    end

    hostreg_irq #(.N(N_ALARM)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_pulse    (wr_pulse),
        .addr        (host_addr),
        .wdata       (host_wdata),
        .alarm_in    (alarm_in),
        .mask        (mask),
        .status      (status),
        .irq_pull_en (irq_pull_en)
    );

    // Power-down control register, always reachable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  pd <= '0;
        else if (wr_pulse && host_addr == ADDR_PWRDN) pd <= host_wdata[NPORT-1:0];
    end

    // Select the read source for the addressed register.
    always_comb begin
        rd_mux = 8'h00;
        case (host_addr)
            ADDR_PWRDN: rd_mux[NPORT-1:0]   = pd;
            ADDR_IMASK: rd_mux[N_ALARM-1:0] = mask;
            ADDR_ISTAT: rd_mux[N_ALARM-1:0] = status;
            default: begin
                if (bank_hit[0])      rd_mux = bank_rd[0];
                else if (bank_hit[1]) rd_mux = bank_rd[1];
            end
        endcase
    end

    // Register the read result at the start of each read.
    always_ff @(posedge clk) begin
        if (!rst_n)        host_rdata <= 8'h00;
        else if (rd_pulse) host_rdata <= rd_mux;
    end

    // R4: the read bus only changes after a read starts.
    assert_rdata_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_pulse |=> $stable(host_rdata));

endmodule

// File: tb/tb_hostreg_port.sv
`timescale 1ns/1ps
module tb_hostreg_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mode = 1'b0;
    logic       host_cs_n = 1'b1, host_strb_n = 1'b1, host_ctl = 1'b1;
    logic [7:0] host_addr = 8'h00, host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] alarm_in = 8'h00;
    logic       irq_pull_en;

    int checks = 0, fails = 0, cyc = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
        int         due;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hostreg_port dut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode),
        .host_cs_n(host_cs_n), .host_strb_n(host_strb_n), .host_ctl(host_ctl),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .alarm_in(alarm_in), .irq_pull_en(irq_pull_en)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items when their read data is due.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                item_t it;
                it = sb_q.pop_front();
                check8(host_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic go_idle();
        host_cs_n = 1'b1; host_strb_n = 1'b1; host_ctl = 1'b1; alarm_in = 8'h00;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic [7:0] al = 8'h00);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_cs_n = 1'b0; host_ctl = 1'b0;
        host_strb_n = bus_mode ? 1'b0 : 1'b1;
        alarm_in = al;
        @(negedge clk);
        go_idle();
    endtask

    // Driver: start a read and push its expected result.
    task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_addr = a; host_cs_n = 1'b0; host_strb_n = 1'b0; host_ctl = 1'b1;
        sb_q.push_back('{exp, tag, cyc + 1});
        @(negedge clk);
        go_idle();
    endtask

    task automatic raw_cycle(input logic s_n, input logic c, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_cs_n = 1'b0; host_strb_n = s_n; host_ctl = c;
        @(negedge clk);
        go_idle();
    endtask

    task automatic pulse_alarm(input logic [7:0] al);
        @(negedge clk);
        alarm_in = al;
        @(negedge clk);
        alarm_in = 8'h00;
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        check8({7'b0, irq_pull_en}, {7'b0, exp}, tag);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1..R11 run): actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check8(host_rdata, 8'h00, "R1 rdata after reset");
        check8({7'b0, irq_pull_en}, 8'h00, "R1 irq after reset");
        bus_read(8'h01, 8'h00, "R1 pwrdn reset");
        bus_read(8'h02, 8'h00, "R1 mask reset");
        bus_read(8'h03, 8'h00, "R1 status reset");
        bus_read(8'h30, 8'h00, "R1 window reset");

        // R7: held value of port B is 0x00 before any B read
        bus_write(8'h60, 8'h5A);
        bus_write(8'h01, 8'h02);
        bus_read(8'h60, 8'h00, "R7 hold after reset");
        bus_write(8'h01, 8'h00);

        // R2/R5: split-strobe writes and read-back at window edges
        bus_write(8'h20, 8'hA5);
        bus_write(8'h45, 8'h3C);
        bus_write(8'h85, 8'hC3);
        bus_read(8'h20, 8'hA5, "R2 read 0x20");
        bus_read(8'h45, 8'h3C, "R5 read 0x45");
        bus_read(8'h60, 8'h5A, "R5 read 0x60");
        bus_read(8'h85, 8'hC3, "R5 read 0x85");
        bus_read(8'h46, 8'h00, "R5 unmapped 0x46");
        bus_read(8'h1F, 8'h00, "R5 unmapped 0x1F");
        bus_write(8'h50, 8'hFF);
        bus_read(8'h50, 8'h00, "R5 unmapped write ignored");

        // R2: both strobes low in split mode is no access
        raw_cycle(1'b0, 1'b0, 8'h20, 8'h11);
        bus_read(8'h20, 8'hA5, "R2 invalid combo ignored");
        // R2: held read strobe gives one access
        @(negedge clk);
        host_addr = 8'h45; host_cs_n = 1'b0; host_strb_n = 1'b0; host_ctl = 1'b1;
        sb_q.push_back('{8'h3C, "R2 held strobe read", cyc + 1});
        repeat (3) @(negedge clk);
        go_idle();
        // R4: rdata holds with no read
        repeat (3) @(negedge clk);
        check8(host_rdata, 8'h3C, "R4 rdata held");

        // R3: strobe-plus-direction mode
        bus_mode = 1'b1;
        bus_write(8'h21, 8'h77);
        bus_read(8'h21, 8'h77, "R3 strobe-mode write/read");
        bus_write(8'h22, 8'h99);
        raw_cycle(1'b1, 1'b0, 8'h22, 8'h00);
        bus_read(8'h22, 8'h99, "R3 no strobe no access");

        // R6/R7/R8: power down port A
        bus_write(8'h01, 8'h01);
        bus_read(8'h01, 8'h01, "R6 pwrdn readback");
        bus_read(8'h20, 8'h99, "R7 A down returns held");
        bus_write(8'h20, 8'h00);
        bus_read(8'h60, 8'h5A, "R6 port B unaffected");
        bus_read(8'h45, 8'h99, "R7 held not updated by B read");
        bus_write(8'h01, 8'h00);
        bus_read(8'h20, 8'hA5, "R8 A contents kept, write dropped");

        // Power down port B
        bus_write(8'h01, 8'h02);
        bus_write(8'h85, 8'h00);
        bus_read(8'h85, 8'h5A, "R7 B down returns held");
        bus_read(8'h21, 8'h77, "R6 port A works while B down");
        bus_write(8'h01, 8'h00);
        bus_read(8'h85, 8'hC3, "R8 B contents kept");

        // R9/R10/R11: alarms, mask, interrupt
        bus_mode = 1'b0;
        pulse_alarm(8'h01);
        check_irq(1'b1, "R11 irq on unmasked alarm");
        bus_read(8'h03, 8'h01, "R9 sticky status");
        bus_write(8'h02, 8'h01);
        check_irq(1'b0, "R10 masked source silent");
        bus_read(8'h03, 8'h01, "R10 mask keeps status");
        bus_read(8'h02, 8'h01, "R10 mask readback");
        pulse_alarm(8'h04);
        check_irq(1'b1, "R11 second source");
        bus_write(8'h03, 8'h04);
        check_irq(1'b0, "R11 cleared source");
        bus_read(8'h03, 8'h01, "R9 clear only written bit");
        bus_write(8'h02, 8'h00);
        check_irq(1'b1, "R10 unmask revives irq");
        bus_write(8'h03, 8'h01);
        check_irq(1'b0, "R11 all clear");
        bus_read(8'h03, 8'h00, "R9 status cleared");
        bus_write(8'h03, 8'h08, 8'h08);
        bus_read(8'h03, 8'h08, "R9 alarm wins over clear");
        check_irq(1'b1, "R11 irq after same-cycle set");
        bus_write(8'h03, 8'h08);
        bus_read(8'h03, 8'h00, "R9 final clear");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard (R4): actual=%0d pending expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule